// File: doc/BRIEF.md
# SPI Master Serial Port

This block is a register-programmed SPI master. Software reaches it through a flat 32-bit register bus: a byte offset, write data, a write strobe, a read strobe and combinational read data. Words written to the data register go into a 16-entry transmit FIFO. A full-duplex shift engine takes each word and sends it on MOSI with a programmable serial clock. It captures one MISO frame for every frame it sends and stores that frame in a 16-entry receive FIFO. Reading the data register pops that FIFO.

Software sets the frame length (4 to 16 bits), the clock divisor, and the clock polarity and phase. A chip-select register drives the slave select line directly; the engine never changes it. A single level interrupt combines three sources, each with its own enable: transmit FIFO low, receive FIFO high, and receive data left waiting while the engine is idle. Clearing the port enable stops the engine and empties both FIFOs.

Top module: `ssp_spi_master`

## Requirements
- R1: After reset, the control words and the chip-select word read 0 and status reads 0x0000_0004. cs_n_o is high, and sclk_o, mosi_o and irq_o are low.
- R2: Control word A at offset 0x000 keeps these fields: frame size minus one in bits 3:0, format in bits 5:4, port enable in bit 7 and divisor minus one in bits 15:8. Control word B at offset 0x004 keeps: receive interrupt enable in bit 0, transmit interrupt enable in bit 1, clock polarity in bit 3, clock phase in bit 4, transmit threshold minus one in bits 9:6, receive threshold minus one in bits 13:10 and idle-timeout interrupt enable in bit 19. Every other bit, and every unmapped offset, reads 0.
- R3: Status at offset 0x008 shows the following, with all other bits 0:
  - bit 2 is set while the transmit FIFO is not full;
  - bit 3 is set while the receive FIFO is not empty;
  - bits 11:8 hold the transmit level modulo 16;
  - bits 15:12 hold the receive level modulo 16.
  A full transmit FIFO therefore reads level 0 with bit 2 clear.
- R4: A write to offset 0x010 while the port is enabled pushes the low frame-size bits of the write data. The write is dropped if the transmit FIFO holds 16 entries or if the port is disabled.
- R5: The engine pops one entry and shifts it out most significant bit first. It stores the bits it samples from MISO as one receive entry, right-aligned. A read of offset 0x010 returns the oldest entry and pops it. A frame that completes while the receive FIFO is full is discarded.
- R6: A bit lasts D input clocks, where D is the divisor field plus one; a field of 0 gives D = 2. Each bit contains one full SCLK period. SCLK rests at the polarity bit when no frame is active.
- R7: MOSI is low when no frame is active, and MISO is sampled at the mid-bit SCLK edge.
  - With phase 0, the MSB is on MOSI at least one clock before the first SCLK edge.
  - With phase 1, the MSB appears in the same clock as the first SCLK edge.
- R8: The frame length is the size field plus one for field values 3 to 15. Field values 0 to 2 give 4 bits.
- R9: While the port is enabled and the transmit interrupt is enabled, irq_o is high whenever the transmit level is at or below the transmit threshold.
- R10: While the port is enabled and the receive interrupt is enabled, irq_o is high whenever the receive level is at or above the receive threshold.
- R11: While the port is enabled and the idle-timeout interrupt is enabled, irq_o is high once the receive FIFO is non-empty and the engine has been idle for 32 clocks.
- R12: Clearing the enable bit does four things:
  - it aborts any frame in progress;
  - it empties both FIFOs;
  - it returns SCLK to its idle level;
  - it holds irq_o low.
- R13: The chip-select word at offset 0x418 controls cs_n_o:
  - with bit 0 set, cs_n_o follows bit 1;
  - with bit 0 clear, cs_n_o is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (pops receive FIFO at the data offset) |
| rdata_o | output | 32 | Read data for addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Slave select, active low |
| irq_o | output | 1 | Level interrupt |

## Verification
MISO is looped back from MOSI, optionally inverted, so every received word is a known function of the sent word. The inverted case separates real sampling from a stale shift register. Random frame lengths, including the clamped short sizes, random divisors, all four clock modes and random data check bit order and masking together. Directed patterns cover the rest:
- A back-to-back burst of seventeen writes under a slow clock shows the level fields wrapping, the full flag and the dropped write.
- Measured SCLK periods and the MOSI value next to the first edge separate divisor and phase errors.
- Threshold, timeout and disable sequences each isolate one interrupt source.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned REG_AW   = 12;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned FRAME_MAX = 16;
  localparam int unsigned FRAME_MIN = 4;
  localparam int unsigned FSZ_W    = $clog2(FRAME_MAX);

  localparam logic [REG_AW-1:0] OFS_CTLA = 12'h000;
  localparam logic [REG_AW-1:0] OFS_CTLB = 12'h004;
  localparam logic [REG_AW-1:0] OFS_STAT = 12'h008;
  localparam logic [REG_AW-1:0] OFS_DATA = 12'h010;
  localparam logic [REG_AW-1:0] OFS_CSEL = 12'h418;

  typedef struct packed {
    logic [DIV_W-1:0] div_m1;
    logic             en;
    logic [1:0]       fmt;
    logic [FSZ_W-1:0] fsz_m1;
  } ctla_t;

  typedef struct packed {
    logic       tmo_ie;
    logic [3:0] rx_thr_m1;
    logic [3:0] tx_thr_m1;
    logic       cpha;
    logic       cpol;
    logic       tx_ie;
    logic       rx_ie;
  } ctlb_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end

  // R4: a push into a full FIFO leaves it at DEPTH
  a_r4_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> count_o == CW'(DEPTH));
  a_r3_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [DIV_W-1:0]       div_m1_i,
  input  logic [$clog2(DW):0]    nbits_i,
  input  logic                   cpol_i,
  input  logic                   cpha_i,
  input  logic                   tx_avail_i,
  input  logic [DW-1:0]          tx_data_i,
  output logic                   tx_pop_o,
  output logic                   rx_push_o,
  output logic [DW-1:0]          rx_data_o,
  output logic                   busy_o,
  output logic                   sclk_o,
  output logic                   mosi_o,
  input  logic                   miso_i
);
  localparam int unsigned SW = $clog2(DW);
  localparam int unsigned PW = DIV_W + 1;

  logic [PW-1:0] period, half, cnt_q;
  logic [SW:0]   bit_q, lsh;
  logic [DW-1:0] tx_sh, rx_sh, fmask;
  logic          busy_q, start, last_cyc;

  assign period   = (div_m1_i == '0) ? PW'(2) : {1'b0, div_m1_i} + PW'(1);
  assign half     = period >> 1;
  assign lsh      = (SW+1)'(DW) - nbits_i;
  assign fmask    = ~({DW{1'b1}} << nbits_i);
  assign start    = run_i && !busy_q && tx_avail_i;
  assign last_cyc = busy_q && (cnt_q == period - PW'(1));

  assign tx_pop_o  = start;
  assign rx_push_o = run_i && last_cyc && (bit_q == '0);
  assign rx_data_o = rx_sh & fmask;
  assign busy_o    = busy_q;
  assign mosi_o    = busy_q && tx_sh[DW-1];
  assign sclk_o    = busy_q ? (cpol_i ^ (cpha_i ? (cnt_q < half) : (cnt_q >= half))) : cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= '0; bit_q <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!run_i) begin
      busy_q <= 1'b0; cnt_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= nbits_i - (SW+1)'(1);
      tx_sh  <= tx_data_i << lsh;
    end else if (busy_q) begin
      if (cnt_q == half - PW'(1)) rx_sh <= {rx_sh[DW-2:0], miso_i};
      if (last_cyc) begin
        cnt_q <= '0;
        tx_sh <= tx_sh << 1;
        if (bit_q == '0) busy_q <= 1'b0;
        else             bit_q  <= bit_q - (SW+1)'(1);
      end else begin
        cnt_q <= cnt_q + PW'(1);
      end
    end
  end

  // R7: MOSI only moves at the start of a bit cell
  a_r7_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && cnt_q != '0 |-> $stable(mosi_o));
endmodule

// File: rtl/ssp_spi_master.sv
module ssp_spi_master
  import ssp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned TMO_CYC    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              irq_o
);
  localparam int unsigned DW = FRAME_MAX;
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  ctla_t ctla_q;
  ctlb_t ctlb_q;
  logic [1:0]    csel_q;
  logic [TW-1:0] idle_q;

  logic [FSZ_W:0] nbits;
  logic [DW-1:0]  fmask, tx_head, rx_head, rx_word;
  logic [CW-1:0]  tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic flush, tx_push, tx_pop, rx_pop, rx_push, eng_busy, tmo_hit;

  assign nbits   = (ctla_q.fsz_m1 < FSZ_W'(FRAME_MIN - 1)) ? (FSZ_W+1)'(FRAME_MIN)
                                                          : {1'b0, ctla_q.fsz_m1} + (FSZ_W+1)'(1);
  assign fmask   = ~({DW{1'b1}} << nbits);
  assign flush   = !ctla_q.en;
  assign tx_push = we_i && (addr_i == OFS_DATA);
  assign rx_pop  = re_i && (addr_i == OFS_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctla_q <= '0; ctlb_q <= '0; csel_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_CTLA: begin
          ctla_q.div_m1 <= wdata_i[15:8];
          ctla_q.en     <= wdata_i[7];
          ctla_q.fmt    <= wdata_i[5:4];
          ctla_q.fsz_m1 <= wdata_i[3:0];
        end
        OFS_CTLB: begin
          ctlb_q.tmo_ie    <= wdata_i[19];
          ctlb_q.rx_thr_m1 <= wdata_i[13:10];
          ctlb_q.tx_thr_m1 <= wdata_i[9:6];
          ctlb_q.cpha      <= wdata_i[4];
          ctlb_q.cpol      <= wdata_i[3];
          ctlb_q.tx_ie     <= wdata_i[1];
          ctlb_q.rx_ie     <= wdata_i[0];
        end
        OFS_CSEL: csel_q <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(tx_push), .data_i(wdata_i[DW-1:0] & fmask),
    .pop_i(tx_pop), .data_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty));

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(rx_push), .data_i(rx_word),
    .pop_i(rx_pop), .data_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty));

  ssp_shifter #(.DW(DW), .DIV_W(DIV_W)) u_shifter (
    .clk_i, .rst_ni, .run_i(ctla_q.en), .div_m1_i(ctla_q.div_m1), .nbits_i(nbits),
    .cpol_i(ctlb_q.cpol), .cpha_i(ctlb_q.cpha), .tx_avail_i(!tx_empty), .tx_data_i(tx_head),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_word), .busy_o(eng_busy),
    .sclk_o, .mosi_o, .miso_i);

  // idle time since the engine last shifted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      idle_q <= '0;
    else if (eng_busy || flush)       idle_q <= '0;
    else if (idle_q != TW'(TMO_CYC))  idle_q <= idle_q + TW'(1);
  end
  assign tmo_hit = (idle_q == TW'(TMO_CYC));

  assign tx_thr = CW'(ctlb_q.tx_thr_m1) + CW'(1);
  assign rx_thr = CW'(ctlb_q.rx_thr_m1) + CW'(1);
  assign irq_o  = ctla_q.en && ((ctlb_q.tx_ie && tx_cnt <= tx_thr) ||
                                (ctlb_q.rx_ie && rx_cnt >= rx_thr) ||
                                (ctlb_q.tmo_ie && !rx_empty && tmo_hit));

  assign cs_n_o = csel_q[0] ? csel_q[1] : 1'b1;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTLA: rdata_o = {16'b0, ctla_q.div_m1, ctla_q.en, 1'b0, ctla_q.fmt, ctla_q.fsz_m1};
      OFS_CTLB: rdata_o = {12'b0, ctlb_q.tmo_ie, 5'b0, ctlb_q.rx_thr_m1, ctlb_q.tx_thr_m1,
                           1'b0, ctlb_q.cpha, ctlb_q.cpol, 1'b0, ctlb_q.tx_ie, ctlb_q.rx_ie};
      OFS_STAT: rdata_o = {16'b0, 4'(rx_cnt), 4'(tx_cnt), 4'b0, !rx_empty, !tx_full, 2'b0};
      OFS_DATA: rdata_o = {{(32-DW){1'b0}}, rx_head};
      OFS_CSEL: rdata_o = {30'b0, csel_q};
      default:  rdata_o = '0;
    endcase
  end

  a_r12_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctla_q.en |=> tx_cnt == '0 && rx_cnt == '0);
  a_r5_start_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_busy) |-> $past(tx_cnt) != '0);
  a_r11_tmo_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ctlb_q.tx_ie && !ctlb_q.rx_ie |-> !rx_empty);
  a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> sclk_o == ctlb_q.cpol);
endmodule

// File: tb/ssp_spi_master_bench.sv
module ssp_spi_master_bench;
  import ssp_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [REG_AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic we = 1'b0, re = 1'b0, inv = 1'b0;
  logic sclk, mosi, miso, cs_n, irq;
  int errors = 0, checks = 0;
  logic [31:0] w [17];

  assign miso = mosi ^ inv;
  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_spi_master u_ssp_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1; #1 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_rne();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(OFS_STAT, s);
      if (s[3]) break;
    end
  endtask

  function automatic int fbits(input int f);
    return (f < 3) ? 4 : f + 1;
  endfunction
  function automatic logic [31:0] rx_exp(input logic [31:0] v, input int f, input logic iv);
    return (iv ? ~v : v) & ((32'd1 << fbits(f)) - 1);
  endfunction
  function automatic logic [31:0] ctla_w(input int en, input int f, input int dv);
    return (32'(dv) << 8) | (32'(en) << 7) | 32'(f);
  endfunction
  function automatic logic [31:0] ctlb_w(input int rie, input int tie, input int cpol, input int cpha,
                                          input int txt, input int rxt, input int tmo);
    return (32'(tmo) << 19) | (32'(rxt) << 10) | (32'(txt) << 6) | (32'(cpha) << 4) |
           (32'(cpol) << 3) | (32'(tie) << 1) | 32'(rie);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFS_CTLA, d); check("R1 ctla", d, 0);
    rd(OFS_CTLB, d); check("R1 ctlb", d, 0);
    rd(OFS_STAT, d); check("R1 status", d, 32'h4);
    rd(OFS_CSEL, d); check("R1 csel", d, 0);
    check("R1 pins", {28'b0, cs_n, sclk, mosi, irq}, 32'b1000);

    // R2 readback, port kept disabled
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = $urandom & ~32'h80;
      wr(OFS_CTLA, v); rd(OFS_CTLA, d); check("R2 ctla", d, v & 32'hFF3F);
      v = $urandom;
      wr(OFS_CTLB, v); rd(OFS_CTLB, d); check("R2 ctlb", d, v & 32'h83FDB);
    end
    rd(12'h00C, d); check("R2 unmapped", d, 0);
    rd(12'h414, d); check("R2 unmapped", d, 0);
    check("R12 irq when disabled", {31'b0, irq}, 0);

    // R13 chip select override
    wr(OFS_CSEL, 32'h1); check("R13 low", {31'b0, cs_n}, 0);
    wr(OFS_CSEL, 32'h3); check("R13 high", {31'b0, cs_n}, 1);
    wr(OFS_CSEL, 32'h1); rd(OFS_CSEL, d); check("R13 readback", d, 1);
    wr(OFS_CSEL, 32'h0); check("R13 sw mode off", {31'b0, cs_n}, 1);

    // R3 R4 R5 burst fill with a slow clock, 4-bit frames
    wr(OFS_CTLB, 0);
    wr(OFS_CTLA, ctla_w(1, 3, 31));
    for (int i = 0; i < 17; i++) w[i] = $urandom;
    for (int i = 0; i < 5; i++) wr(OFS_DATA, w[i]);
    rd(OFS_STAT, d); check("R3 level 4", d, 32'h0404);
    for (int i = 5; i < 17; i++) wr(OFS_DATA, w[i]);
    rd(OFS_STAT, d); check("R3 tx full wraps", d, 32'h0000);
    wr(OFS_DATA, 32'h5);
    rd(OFS_STAT, d); check("R4 write when full dropped", d, 32'h0000);
    repeat (2600) @(negedge clk);
    rd(OFS_STAT, d); check("R3 rx full wraps", d, 32'h000C);
    for (int i = 0; i < 16; i++) begin
      rd(OFS_DATA, d); check("R5 burst order", d, w[i] & 32'hF);
    end
    rd(OFS_STAT, d); check("R5 overflow frame discarded", d, 32'h4);

    // R5 R8 random frames, modes, divisors, loopback polarity
    for (int i = 0; i < 12; i++) begin
      int f, dv, md;
      logic [31:0] v;
      f = $urandom_range(0, 15); dv = $urandom_range(0, 7); md = $urandom_range(0, 3);
      inv = 1'($urandom_range(0, 1)); v = $urandom;
      wr(OFS_CTLB, ctlb_w(0, 0, md >> 1, md & 1, 0, 0, 0));
      wr(OFS_CTLA, ctla_w(1, f, dv));
      wr(OFS_DATA, v);
      wait_rne();
      rd(OFS_DATA, d); check("R5 R8 random frame", d, rx_exp(v, f, inv));
    end
    inv = 1'b0;
    wr(OFS_CTLB, 0);
    wr(OFS_CTLA, ctla_w(1, 15, 2)); wr(OFS_DATA, 32'hA5C3);
    wait_rne(); rd(OFS_DATA, d); check("R8 16-bit frame", d, 32'hA5C3);
    wr(OFS_CTLA, ctla_w(1, 1, 2)); wr(OFS_DATA, 32'hFFFF);
    wait_rne(); rd(OFS_DATA, d); check("R8 short field clamps to 4", d, 32'hF);

    // R6 idle level and period, divisor field 4 gives 5 clocks
    begin
      int n, k;
      wr(OFS_CTLB, ctlb_w(0, 0, 1, 0, 0, 0, 0));
      wr(OFS_CTLA, ctla_w(1, 7, 4));
      check("R6 idle high", {31'b0, sclk}, 1);
      wr(OFS_DATA, 32'h0);
      k = 0;
      while (sclk == 1'b1 && k < 1000) begin @(negedge clk); k++; end
      n = 0;
      do begin @(negedge clk); n++; end while (sclk == 1'b0 && n < 1000);
      do begin @(negedge clk); n++; end while (sclk == 1'b1 && n < 1000);
      check("R6 period", 32'(n), 5);
      wait_rne(); rd(OFS_DATA, d); check("R6 data", d, 0);
    end

    // R7 phase: MOSI next to the first edge
    for (int ph = 0; ph < 2; ph++) begin
      logic pm;
      int k;
      wr(OFS_CTLB, ctlb_w(0, 0, 0, ph, 0, 0, 0));
      wr(OFS_CTLA, ctla_w(1, 7, 7));
      wr(OFS_DATA, 32'h80);
      pm = mosi; k = 0;
      while (k < 1000) begin
        @(negedge clk); k++;
        if (sclk != 1'b0) break;
        pm = mosi;
      end
      check("R7 mosi before first edge", {31'b0, pm}, (ph == 0) ? 1 : 0);
      check("R7 mosi at first edge", {31'b0, mosi}, 1);
      wait_rne(); rd(OFS_DATA, d); check("R7 data", d, 32'h80);
    end

    // R10 receive threshold 2
    wr(OFS_CTLB, ctlb_w(1, 0, 0, 0, 0, 1, 0));
    wr(OFS_CTLA, ctla_w(1, 3, 1));
    wr(OFS_DATA, 32'h5); repeat (30) @(negedge clk);
    check("R10 below threshold", {31'b0, irq}, 0);
    wr(OFS_DATA, 32'h6); repeat (30) @(negedge clk);
    check("R10 at threshold", {31'b0, irq}, 1);
    rd(OFS_DATA, d); check("R10 data", d, 5);
    check("R10 after pop", {31'b0, irq}, 0);
    rd(OFS_DATA, d);

    // R11 idle timeout
    wr(OFS_CTLB, ctlb_w(0, 0, 0, 0, 0, 0, 1));
    wr(OFS_DATA, 32'h9); repeat (12) @(negedge clk);
    check("R11 before timeout", {31'b0, irq}, 0);
    repeat (40) @(negedge clk);
    check("R11 after timeout", {31'b0, irq}, 1);
    rd(OFS_DATA, d); check("R11 after pop", {31'b0, irq}, 0);

    // R9 transmit threshold 2, then R12 disable
    wr(OFS_CTLB, ctlb_w(0, 1, 0, 0, 1, 0, 0));
    wr(OFS_CTLA, ctla_w(1, 15, 255));
    check("R9 empty", {31'b0, irq}, 1);
    for (int i = 0; i < 4; i++) wr(OFS_DATA, 32'hFFFF);
    check("R9 above threshold", {31'b0, irq}, 0);
    rd(OFS_STAT, d); check("R3 tx level 3", d, 32'h0304);
    wr(OFS_CTLA, ctla_w(0, 15, 255));
    rd(OFS_STAT, d); check("R12 flushed", d, 32'h4);
    check("R12 pins idle", {29'b0, sclk, mosi, irq}, 0);
    wr(OFS_DATA, 32'h7);
    wr(OFS_CTLA, ctla_w(1, 3, 1));
    repeat (200) @(negedge clk);
    rd(OFS_STAT, d); check("R4 R12 nothing left to send", d, 32'h4);

    summary();
    $finish;
  end
endmodule